// File: doc/BRIEF.md
# Version-Stamped Compare-And-Swap Register

This block holds one shared word together with a version stamp and lets several requesters update it with a compare-and-swap. A requester names the word and stamp it believes are current, plus the word and stamp it wants stored. The store happens only when both halves of that belief are correct. Because every successful store moves the stamp forward, a word that is changed and then changed back still looks different to a requester holding an old stamp. A requester can also take a read, which returns the word and its stamp as one consistent pair.

Requests arrive on parallel request lanes, one lane per requester. A fixed-priority arbiter serves one lane per clock, and the lowest lane index wins. Every other lane that asked in that cycle gets a busy answer and must ask again. A failed compare returns the current contents, so the requester can retry at once. Each lane also has a saturating retry counter that software or a back-off engine can watch. The word is usually several narrow variables packed side by side, which are then swapped as one unit.

Top module: `vcas_reg`

## Requirements
- R1: After reset the stored word and stamp are zero, every `rsp_valid` bit is low and every retry counter is zero.
- R2: Op code 2'b00 (read) and op code 2'b11 (peek) both answer status 2'b00 (OK) with the stored word and stamp, and leave both unchanged.
- R3: Op code 2'b01 (stamped CAS) succeeds only when the stored word equals the expected word and the stored stamp equals the expected stamp. On success the word and stamp are both replaced at the same clock edge, and the answer is OK carrying the newly stored word and stamp.
- R4: A CAS whose expected word (any bit, including bits in the upper packed field) or expected stamp differs answers status 2'b01 (FAIL) with the current word and stamp, and changes neither.
- R5: Op code 2'b10 (auto-stamp CAS) compares like R3 and, on success, stores the stamp as the old stamp plus one. It wraps from all-ones to zero and ignores the supplied new stamp.
- R6: After a word is changed and then restored with auto-stamp CAS, a CAS that presents the original word with the original stamp fails.
- R7: When several lanes request in one cycle, only the lowest-index lane is served. Every other requesting lane answers status 2'b10 (BUSY), and their requests have no effect on the stored state.
- R8: `rsp_valid[i]` is high in the cycle after a clock edge that sampled `req_valid[i]` high, and low otherwise. All answers are registered and take one cycle.
- R9: A lane's retry counter goes up by one on every BUSY or FAIL answer, saturates at its maximum, and clears on an OK answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NREQ | Request present, one bit per lane |
| req_op | input | 2*NREQ | Op code per lane: 00 read, 01 stamped CAS, 10 auto-stamp CAS, 11 peek |
| req_exp_val | input | DATA_W*NREQ | Expected word per lane |
| req_exp_stamp | input | STAMP_W*NREQ | Expected stamp per lane |
| req_new_val | input | DATA_W*NREQ | Word to store per lane |
| req_new_stamp | input | STAMP_W*NREQ | Stamp to store per lane (stamped CAS only) |
| rsp_valid | output | NREQ | Answer present, one bit per lane |
| rsp_status | output | 2*NREQ | Status per lane: 00 OK, 01 FAIL, 10 BUSY |
| rsp_val | output | DATA_W | Word returned to the served lane |
| rsp_stamp | output | STAMP_W | Stamp returned to the served lane |
| retry_cnt | output | RETRY_W*NREQ | Saturating retry counter per lane |

## Verification
Any corruption of the stored word or stamp shows up at the next read or CAS to reach the arbiter. That access either returns the wrong pair or flips the status between OK and FAIL, one cycle after the request is sampled. A wrong grant shows on the same answer cycle, as a BUSY on the lane that should have won or as two lanes both reported as served. A retry counter that drifts is visible on `retry_cnt` in the cycle right after the answer that should have moved it.

// File: rtl/vcas_pkg.sv
package vcas_pkg;

   typedef enum logic [1:0] {
      OP_READ     = 2'b00,
      OP_CAS      = 2'b01,
      OP_CAS_AUTO = 2'b10,
      OP_PEEK     = 2'b11
   } vcas_op_e;

   typedef enum logic [1:0] {
      ST_OK   = 2'b00,
      ST_FAIL = 2'b01,
      ST_BUSY = 2'b10,
      ST_RSVD = 2'b11
   } vcas_st_e;

endpackage

// File: rtl/vcas_arb.sv
module vcas_arb #(
   parameter int N = 4
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt,
   output logic         any
);
   generate
      if (N == 1) begin : g_single
         assign gnt = req;
      end else begin : g_chain
         logic [N:0] blocked;
         assign blocked[0] = 1'b0;
         for (genvar i = 0; i < N; i++) begin : g_lane
            assign gnt[i]       = req[i] & ~blocked[i];
            assign blocked[i+1] = blocked[i] | req[i];
         end
      end
   endgenerate

   assign any = |req;
endmodule

// File: rtl/vcas_core.sv
module vcas_core
   import vcas_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int STAMP_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               do_op,
   input  vcas_op_e           op,
   input  logic [DATA_W-1:0]  exp_val,
   input  logic [STAMP_W-1:0] exp_stamp,
   input  logic [DATA_W-1:0]  new_val,
   input  logic [STAMP_W-1:0] new_stamp,
   output logic [DATA_W-1:0]  cur_val,
   output logic [STAMP_W-1:0] cur_stamp,
   output vcas_st_e           status,
   output logic [DATA_W-1:0]  res_val,
   output logic [STAMP_W-1:0] res_stamp
);
   logic               is_cas;
   logic               match;
   logic               commit;
   logic [STAMP_W-1:0] next_stamp;

   assign is_cas = (op == OP_CAS) || (op == OP_CAS_AUTO);
   assign match  = (cur_val == exp_val) && (cur_stamp == exp_stamp);
   assign commit = do_op && is_cas && match;

   // Auto mode moves the stamp forward by one, wrapping naturally.
   assign next_stamp = (op == OP_CAS_AUTO) ? cur_stamp + STAMP_W'(1) : new_stamp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_val   <= '0;
         cur_stamp <= '0;
      end else if (commit) begin
         cur_val   <= new_val;
         cur_stamp <= next_stamp;
      end
   end

   always_comb begin
      if (is_cas && match) begin
         status    = ST_OK;
         res_val   = new_val;
         res_stamp = next_stamp;
      end else if (is_cas) begin
         status    = ST_FAIL;
         res_val   = cur_val;
         res_stamp = cur_stamp;
      end else begin
         status    = ST_OK;
         res_val   = cur_val;
         res_stamp = cur_stamp;
      end
   end
endmodule

// File: rtl/vcas_retry.sv
module vcas_retry #(
   parameter int N = 4,
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] bump,
   input  logic [N-1:0] clear,
   output logic [W*N-1:0] cnt
);
   localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

   generate
      for (genvar i = 0; i < N; i++) begin : g_ctr
         logic [W-1:0] c;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      c <= '0;
            else if (clear[i])               c <= '0;
            else if (bump[i] && c != CNT_MAX) c <= c + W'(1);
         end
         assign cnt[W*i +: W] = c;
      end
   endgenerate
endmodule

// File: rtl/vcas_reg.sv
module vcas_reg
   import vcas_pkg::*;
#(
   parameter int NREQ    = 4,
   parameter int DATA_W  = 32,
   parameter int STAMP_W = 16,
   parameter int RETRY_W = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NREQ-1:0]           req_valid,
   input  logic [2*NREQ-1:0]         req_op,
   input  logic [DATA_W*NREQ-1:0]    req_exp_val,
   input  logic [STAMP_W*NREQ-1:0]   req_exp_stamp,
   input  logic [DATA_W*NREQ-1:0]    req_new_val,
   input  logic [STAMP_W*NREQ-1:0]   req_new_stamp,
   output logic [NREQ-1:0]           rsp_valid,
   output logic [2*NREQ-1:0]         rsp_status,
   output logic [DATA_W-1:0]         rsp_val,
   output logic [STAMP_W-1:0]        rsp_stamp,
   output logic [RETRY_W*NREQ-1:0]   retry_cnt
);
   generate
      if (NREQ < 1 || NREQ > 32) begin : g_bad_nreq
         $error("vcas_reg: NREQ must lie in 1..32");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("vcas_reg: DATA_W must be positive");
      end
      if (STAMP_W < 2) begin : g_bad_stamp
         $error("vcas_reg: STAMP_W must be at least 2");
      end
      if (RETRY_W < 1) begin : g_bad_retry
         $error("vcas_reg: RETRY_W must be positive");
      end
   endgenerate

   logic [NREQ-1:0]    gnt;
   logic               any_req;
   vcas_op_e           sel_op;
   logic [DATA_W-1:0]  sel_exp_val, sel_new_val;
   logic [STAMP_W-1:0] sel_exp_stamp, sel_new_stamp;
   logic [DATA_W-1:0]  cur_val, res_val;
   logic [STAMP_W-1:0] cur_stamp, res_stamp;
   vcas_st_e           core_st;
   logic [NREQ-1:0]    bump, clear;

   vcas_arb #(.N(NREQ)) u_arb (
      .req (req_valid),
      .gnt (gnt),
      .any (any_req)
   );

   // One-hot grant selects the winning lane's operands.
   always_comb begin
      sel_op        = OP_READ;
      sel_exp_val   = '0;
      sel_exp_stamp = '0;
      sel_new_val   = '0;
      sel_new_stamp = '0;
      for (int i = 0; i < NREQ; i++) begin
         if (gnt[i]) begin
            sel_op        = vcas_op_e'(req_op[2*i +: 2]);
            sel_exp_val   = req_exp_val[DATA_W*i +: DATA_W];
            sel_exp_stamp = req_exp_stamp[STAMP_W*i +: STAMP_W];
            sel_new_val   = req_new_val[DATA_W*i +: DATA_W];
            sel_new_stamp = req_new_stamp[STAMP_W*i +: STAMP_W];
         end
      end
   end

   vcas_core #(.DATA_W(DATA_W), .STAMP_W(STAMP_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .do_op     (any_req),
      .op        (sel_op),
      .exp_val   (sel_exp_val),
      .exp_stamp (sel_exp_stamp),
      .new_val   (sel_new_val),
      .new_stamp (sel_new_stamp),
      .cur_val   (cur_val),
      .cur_stamp (cur_stamp),
      .status    (core_st),
      .res_val   (res_val),
      .res_stamp (res_stamp)
   );

   generate
      for (genvar i = 0; i < NREQ; i++) begin : g_lane
         assign bump[i]  = req_valid[i] & (~gnt[i] | (core_st == ST_FAIL));
         assign clear[i] = gnt[i] & (core_st == ST_OK);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               rsp_status[2*i +: 2] <= ST_OK;
            else if (gnt[i])
               rsp_status[2*i +: 2] <= core_st;
            else if (req_valid[i])
               rsp_status[2*i +: 2] <= ST_BUSY;
            else
               rsp_status[2*i +: 2] <= ST_OK;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= '0;
         rsp_val   <= '0;
         rsp_stamp <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_val   <= any_req ? res_val   : '0;
         rsp_stamp <= any_req ? res_stamp : '0;
      end
   end

   vcas_retry #(.N(NREQ), .W(RETRY_W)) u_retry (
      .clk   (clk),
      .rst_n (rst_n),
      .bump  (bump),
      .clear (clear),
      .cnt   (retry_cnt)
   );
endmodule

// File: rtl/vcas_reg_chk.sv
module vcas_reg_chk #(
   parameter int NREQ    = 4,
   parameter int DATA_W  = 32,
   parameter int STAMP_W = 16,
   parameter int RETRY_W = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [NREQ-1:0]         req_valid,
   input logic [NREQ-1:0]         rsp_valid,
   input logic [2*NREQ-1:0]       rsp_status,
   input logic [DATA_W-1:0]       cur_val,
   input logic [STAMP_W-1:0]      cur_stamp,
   input logic [RETRY_W*NREQ-1:0] retry_cnt
);
   logic [NREQ-1:0] won, ok, failed;

   always_comb begin
      for (int i = 0; i < NREQ; i++) begin
         won[i]    = rsp_valid[i] && (rsp_status[2*i +: 2] != 2'b10);
         ok[i]     = won[i] && (rsp_status[2*i +: 2] == 2'b00);
         failed[i] = won[i] && (rsp_status[2*i +: 2] == 2'b01);
      end
   end

   p_single_winner_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(won));

   p_fail_keeps_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|failed) |-> (cur_val == $past(cur_val) && cur_stamp == $past(cur_stamp)));

   p_change_needs_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_val != $past(cur_val) || cur_stamp != $past(cur_stamp)) |-> (|ok));

   generate
      for (genvar i = 0; i < NREQ; i++) begin : g_lane
         p_rsp_follows_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_valid[i] |-> $past(req_valid[i]));

         p_retry_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (retry_cnt[RETRY_W*i +: RETRY_W] != $past(retry_cnt[RETRY_W*i +: RETRY_W])) |->
            (retry_cnt[RETRY_W*i +: RETRY_W] == '0 ||
             retry_cnt[RETRY_W*i +: RETRY_W] == $past(retry_cnt[RETRY_W*i +: RETRY_W]) + RETRY_W'(1)));
      end
   endgenerate
endmodule

bind vcas_reg vcas_reg_chk #(
   .NREQ(NREQ), .DATA_W(DATA_W), .STAMP_W(STAMP_W), .RETRY_W(RETRY_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .rsp_valid  (rsp_valid),
   .rsp_status (rsp_status),
   .cur_val    (cur_val),
   .cur_stamp  (cur_stamp),
   .retry_cnt  (retry_cnt)
);

// File: tb/tb_vcas_reg.sv
module tb_vcas_reg;
   localparam int N = 4;
   localparam int DW = 32;
   localparam int SW = 16;
   localparam int RW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [N-1:0]    req_valid;
   logic [2*N-1:0]  req_op;
   logic [DW*N-1:0] req_exp_val, req_new_val;
   logic [SW*N-1:0] req_exp_stamp, req_new_stamp;
   logic [N-1:0]    rsp_valid;
   logic [2*N-1:0]  rsp_status;
   logic [DW-1:0]   rsp_val;
   logic [SW-1:0]   rsp_stamp;
   logic [RW*N-1:0] retry_cnt;

   vcas_reg #(.NREQ(N), .DATA_W(DW), .STAMP_W(SW), .RETRY_W(RW)) dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_op(req_op),
      .req_exp_val(req_exp_val), .req_exp_stamp(req_exp_stamp),
      .req_new_val(req_new_val), .req_new_stamp(req_new_stamp),
      .rsp_valid(rsp_valid), .rsp_status(rsp_status),
      .rsp_val(rsp_val), .rsp_stamp(rsp_stamp), .retry_cnt(retry_cnt)
   );

   typedef struct {
      logic [N-1:0]    vld;
      logic [2*N-1:0]  st;
      logic            served;
      logic [DW-1:0]   val;
      logic [SW-1:0]   stamp;
      logic [RW*N-1:0] retry;
      string           tag;
   } exp_t;

   exp_t exq[$];
   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // bench-side model state
   logic [DW-1:0] m_val = '0;
   logic [SW-1:0] m_stamp = '0;
   logic [RW-1:0] m_retry [N];

   // per-lane stimulus for the next cycle
   logic          s_v  [N];
   logic [1:0]    s_op [N];
   logic [DW-1:0] s_ev [N], s_nv [N];
   logic [SW-1:0] s_es [N], s_ns [N];

   task automatic clear_stim();
      for (int i = 0; i < N; i++) begin
         s_v[i] = 0; s_op[i] = 0; s_ev[i] = 0; s_nv[i] = 0; s_es[i] = 0; s_ns[i] = 0;
      end
   endtask

   task automatic put(int i, logic [1:0] op, logic [DW-1:0] ev, logic [SW-1:0] es,
                      logic [DW-1:0] nv, logic [SW-1:0] ns);
      s_v[i] = 1; s_op[i] = op; s_ev[i] = ev; s_es[i] = es; s_nv[i] = nv; s_ns[i] = ns;
   endtask

   function automatic logic [RW-1:0] sat_inc(logic [RW-1:0] c);
      return (c == {RW{1'b1}}) ? c : c + RW'(1);
   endfunction

   // driver: applies one cycle of stimulus at the falling edge and queues the expectation
   task automatic step(string tag);
      exp_t e;
      int g = -1;
      for (int i = 0; i < N; i++) begin
         req_valid[i]               = s_v[i];
         req_op[2*i +: 2]           = s_op[i];
         req_exp_val[DW*i +: DW]    = s_ev[i];
         req_exp_stamp[SW*i +: SW]  = s_es[i];
         req_new_val[DW*i +: DW]    = s_nv[i];
         req_new_stamp[SW*i +: SW]  = s_ns[i];
         if (s_v[i] && g < 0) g = i;
      end
      e.tag = tag; e.vld = '0; e.st = '0; e.served = (g >= 0); e.val = '0; e.stamp = '0;
      for (int i = 0; i < N; i++) begin
         e.vld[i] = s_v[i];
         if (s_v[i] && i != g) begin
            e.st[2*i +: 2] = 2'b10;
            m_retry[i] = sat_inc(m_retry[i]);
         end
      end
      if (g >= 0) begin
         if (s_op[g] == 2'b01 || s_op[g] == 2'b10) begin
            if (m_val == s_ev[g] && m_stamp == s_es[g]) begin
               m_val   = s_nv[g];
               m_stamp = (s_op[g] == 2'b10) ? m_stamp + 16'd1 : s_ns[g];
               e.st[2*g +: 2] = 2'b00;
               m_retry[g] = '0;
            end else begin
               e.st[2*g +: 2] = 2'b01;
               m_retry[g] = sat_inc(m_retry[g]);
            end
         end else begin
            e.st[2*g +: 2] = 2'b00;
            m_retry[g] = '0;
         end
         e.val = m_val; e.stamp = m_stamp;
      end
      for (int i = 0; i < N; i++) e.retry[RW*i +: RW] = m_retry[i];
      exq.push_back(e);
      @(negedge clk);
      clear_stim();
   endtask

   // monitor: compares registered answers shortly after each rising edge
   always @(posedge clk) begin
      #2;
      if (exq.size() > 0) begin
         exp_t e;
         e = exq.pop_front();
         checks++;
         if (rsp_valid !== e.vld || rsp_status !== e.st || retry_cnt !== e.retry ||
             (e.served && (rsp_val !== e.val || rsp_stamp !== e.stamp))) begin
            fails++;
            $display("FAIL %s: got vld=%b st=%b val=%h stamp=%h retry=%h, expected vld=%b st=%b val=%h stamp=%h retry=%h",
                     e.tag, rsp_valid, rsp_status, rsp_val, rsp_stamp, retry_cnt,
                     e.vld, e.st, e.val, e.stamp, e.retry);
         end
      end
   end

   initial begin
      #(20 * 20000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got no completion, expected end of run");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) m_retry[i] = '0;
      clear_stim();
      req_valid = '0; req_op = '0; req_exp_val = '0; req_new_val = '0;
      req_exp_stamp = '0; req_new_stamp = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state at the ports
      checks++;
      if (rsp_valid !== '0 || retry_cnt !== '0) begin
         fails++;
         $display("FAIL R1 reset: got vld=%b retry=%h, expected 0 and 0", rsp_valid, retry_cnt);
      end
      put(2, 2'b00, 0, 0, 0, 0); step("R1 R2 read after reset is zero");

      // R3: stamped CAS success
      put(1, 2'b01, 32'h0, 16'h0, 32'h0000_000A, 16'h0005); step("R3 stamped CAS hit");
      // R4: stamp mismatch, then value mismatch
      put(0, 2'b01, 32'h0000_000A, 16'h0004, 32'hDEAD_BEEF, 16'h0009); step("R4 stamp mismatch");
      put(0, 2'b01, 32'h0000_000B, 16'h0005, 32'hDEAD_BEEF, 16'h0009); step("R4 value mismatch");
      // R4: packed upper field differs only
      put(0, 2'b01, 32'h0001_000A, 16'h0005, 32'hDEAD_BEEF, 16'h0009); step("R4 upper packed field mismatch");
      put(0, 2'b01, 32'h0000_000A, 16'h0005, 32'h1234_0056, 16'h0007); step("R3 packed fields swapped together");

      // R5 R6: A-B-A with auto stamp, supplied new stamp ignored
      put(1, 2'b10, 32'h1234_0056, 16'h0007, 32'h0000_000A, 16'hBEEF); step("R5 auto stamp increments");
      put(1, 2'b10, 32'h0000_000A, 16'h0008, 32'h1234_0056, 16'h1111); step("R5 auto stamp restore word");
      put(2, 2'b01, 32'h1234_0056, 16'h0007, 32'h7777_7777, 16'h0001); step("R6 stale stamp after ABA fails");
      put(2, 2'b10, 32'h1234_0056, 16'h0009, 32'h5555_0000, 16'h0000); step("R6 fresh stamp succeeds");

      // R5: wrap from all-ones to zero
      put(3, 2'b01, 32'h5555_0000, 16'h000A, 32'h5555_0001, 16'hFFFF); step("R3 set stamp all ones");
      put(3, 2'b10, 32'h5555_0001, 16'hFFFF, 32'h5555_0002, 16'h0042); step("R5 stamp wraps to zero");

      // R2: peek leaves state alone
      put(0, 2'b11, 32'hFFFF_FFFF, 16'hFFFF, 32'h0, 16'h0); step("R2 peek returns contents");
      put(1, 2'b00, 0, 0, 0, 0); step("R2 read after peek unchanged");

      // R8: idle cycle
      step("R8 no request gives no answer");

      // R7: contention; lane 3 would have succeeded
      put(0, 2'b10, 32'h5555_0002, 16'h0000, 32'hAAAA_0000, 16'h0000);
      put(2, 2'b01, 32'h5555_0002, 16'h0000, 32'hBBBB_0000, 16'h0003);
      put(3, 2'b10, 32'h5555_0002, 16'h0000, 32'hCCCC_0000, 16'h0000);
      step("R7 lowest lane wins, others busy");
      put(1, 2'b00, 0, 0, 0, 0); step("R7 losers left no trace");

      // R9: saturation of lane 3 while lane 2 holds the arbiter
      for (int k = 0; k < 17; k++) begin
         put(2, 2'b00, 0, 0, 0, 0);
         put(3, 2'b00, 0, 0, 0, 0);
         step("R9 retry count saturates");
      end
      put(3, 2'b00, 0, 0, 0, 0); step("R9 OK answer clears count");

      // R9: failure bumps, success clears
      put(1, 2'b01, 32'h0, 16'h0, 32'h1, 16'h1); step("R9 FAIL bumps count");
      put(1, 2'b01, 32'hAAAA_0000, 16'h0001, 32'h0BAD_F00D, 16'h0100); step("R9 success clears count");
      put(0, 2'b00, 0, 0, 0, 0); step("R3 final contents");

      @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule